// File: doc/BRIEF.md
# CRC Accumulate Instruction Execute Unit

This unit sits in the execute stage of a 32-bit processor pipeline. Each cycle that `in_valid` is high, it receives a 32-bit instruction word and the values of two source registers, one holding the running checksum and one holding the new data. It works out whether the word is one of the two CRC-accumulate instructions. It checks the encoding for uses that must trap. For a legal instruction it folds one byte, halfword or word of data into the checksum. Bit 9 of the word picks the polynomial: the ISO polynomial or the Castagnoli polynomial.

All outputs come from registers one clock after the strobe. A legal instruction gives `wr_en`, the destination index and the new checksum. An instruction with an illegal condition, size or register index gives `unpred` and no write. A word that is not a CRC instruction gives all flags low. The register file, condition-flag evaluation and the other instructions are outside this block. The unit does no initial or final inversion, so software applies those around a sequence of instructions.

A two-state machine marks when the outputs are valid. `ST_IDLE` becomes `ST_SHOW` on a strobe. `ST_SHOW` stays in `ST_SHOW` while strobes keep arriving and returns to `ST_IDLE` on a cycle without one. `out_valid` is high in `ST_SHOW`.

Top module: `crc_instr_unit`

## Requirements
- R1: `match` is high one cycle after a strobe only when bits 27:23 of the word are 00010, bit 20 is 0, bits 11:10 are 00, bit 8 is 0 and bits 7:4 are 0100.
- R2: On a legal instruction, `dest_idx` carries bits 15:12 of the word and `wr_en` is high. The accumulator register index is in bits 19:16 and the data register index is in bits 3:0.
- R3: Bit 9 selects the polynomial: 0 selects the reflected ISO polynomial 0xEDB88320 and 1 selects the reflected Castagnoli polynomial 0x82F63B78. Data is consumed least significant bit first, with no inversion.
- R4: Size bits 22:21 set the data width: 00 is the low 8 bits, 01 the low 16 bits and 10 all 32 bits. The upper data bits have no effect. A halfword or word gives the same result as successive byte steps, lowest byte first.
- R5: A size of 11 raises `unpred` and keeps `wr_en` low.
- R6: A condition field (bits 31:28) other than 1110 raises `unpred` and keeps `wr_en` low.
- R7: A register index of 15 in the destination, accumulator or data field raises `unpred` and keeps `wr_en` low.
- R8: A word that does not match gives `match`, `wr_en` and `unpred` all low.
- R9: Outputs update on the clock edge that samples `in_valid` high. `out_valid` follows the strobe by one cycle. In a cycle after no strobe, `match`, `wr_en` and `unpred` are low.
- R10: While reset is active, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| acc_val | input | 32 | Value of the accumulator source register |
| dat_val | input | 32 | Value of the data source register |
| out_valid | output | 1 | Outputs belong to the previous strobe |
| match | output | 1 | Word was a CRC-accumulate instruction |
| wr_en | output | 1 | Write `result` to `dest_idx` |
| unpred | output | 1 | Unpredictable-use trap |
| dest_idx | output | 4 | Destination register index |
| result | output | 32 | Updated checksum |

## Verification
The hardest case to reach is a correct CRC across a long chain of instructions, where each result becomes the next accumulator and the widths are mixed. A single-step error in bit order or byte order can cancel out in short random cases. The bench therefore feeds a standard nine-character check string back through the unit, once with byte instructions only and once as two words plus a byte, and compares both against the known check value. Random words, including trap cases and near-miss encodings, are mixed with these directed checks.

// File: rtl/crc_unit_pkg.sv
package crc_unit_pkg;
    localparam int unsigned XLEN = 32;
    localparam logic [XLEN-1:0] POLY_ISO  = 32'hEDB88320;
    localparam logic [XLEN-1:0] POLY_CAST = 32'h82F63B78;
    localparam logic [3:0]      COND_ALWAYS = 4'hE;
    localparam logic [3:0]      PC_INDEX    = 4'hF;

    typedef enum logic [0:0] {ST_IDLE, ST_SHOW} show_state_t;

    typedef struct packed {
        logic       hit;
        logic       trap;
        logic       castagnoli;
        logic [1:0] size;
        logic [3:0] rd;
    } crc_dec_t;

    // One reflected byte step, least significant bit first.
    function automatic logic [XLEN-1:0] crc_byte_step(
        input logic [XLEN-1:0] cur,
        input logic [7:0]      din,
        input logic [XLEN-1:0] poly);
        logic [XLEN-1:0] c;
        c = cur ^ {{(XLEN-8){1'b0}}, din};
        for (int k = 0; k < 8; k++) begin
            c = c[0] ? ((c >> 1) ^ poly) : (c >> 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/crc_decode.sv
module crc_decode
    import crc_unit_pkg::*;
(
    input  logic [31:0] word,
    output crc_dec_t    dec
);
    logic [3:0] cond_f, rn_f, rd_f, rm_f;
    logic       fixed_ok, pc_used;

    assign cond_f = word[31:28];
    assign rn_f   = word[19:16];
    assign rd_f   = word[15:12];
    assign rm_f   = word[3:0];

    assign fixed_ok = (word[27:23] == 5'b00010) && !word[20] &&
                      (word[11:10] == 2'b00) && !word[8] &&
                      (word[7:4] == 4'b0100);
    assign pc_used  = (rd_f == PC_INDEX) || (rn_f == PC_INDEX) || (rm_f == PC_INDEX);

    always_comb begin
        dec.hit        = fixed_ok;
        dec.castagnoli = word[9];
        dec.size       = word[22:21];
        dec.rd         = rd_f;
        dec.trap       = fixed_ok &&
                         ((cond_f != COND_ALWAYS) || (word[22:21] == 2'b11) || pc_used);
    end
endmodule

// File: rtl/crc_fold.sv
module crc_fold
    import crc_unit_pkg::*;
#(
    parameter int unsigned WIDTH = XLEN
) (
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] data,
    input  logic             castagnoli,
    input  logic [1:0]       size,
    output logic [WIDTH-1:0] crc_out
);
    localparam int unsigned NBYTES = WIDTH / 8;

    logic [WIDTH-1:0] poly;
    logic [WIDTH-1:0] chain [NBYTES+1];

    assign poly     = castagnoli ? POLY_CAST : POLY_ISO;
    assign chain[0] = acc;

    // Bytes enter lowest first; each stage folds one more byte.
    for (genvar b = 0; b < NBYTES; b++) begin : g_stage
        assign chain[b+1] = crc_byte_step(chain[b], data[8*b +: 8], poly);
    end

    always_comb begin
        unique case (size)
            2'b00:   crc_out = chain[1];
            2'b01:   crc_out = chain[2];
            default: crc_out = chain[NBYTES];
        endcase
    end
endmodule

// File: rtl/crc_instr_unit.sv
module crc_instr_unit
    import crc_unit_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] instr,
    input  logic [31:0] acc_val,
    input  logic [31:0] dat_val,
    output logic        out_valid,
    output logic        match,
    output logic        wr_en,
    output logic        unpred,
    output logic [3:0]  dest_idx,
    output logic [31:0] result
);
    crc_dec_t    dec;
    logic [31:0] folded;
    show_state_t state, state_nx;

    crc_decode u_dec (.word(instr), .dec(dec));

    crc_fold #(.WIDTH(XLEN)) u_fold (
        .acc(acc_val), .data(dat_val), .castagnoli(dec.castagnoli),
        .size(dec.size), .crc_out(folded)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid)  state_nx = ST_SHOW;
            ST_SHOW: if (!in_valid) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign out_valid = (state == ST_SHOW);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match    <= 1'b0;
            wr_en    <= 1'b0;
            unpred   <= 1'b0;
            dest_idx <= '0;
            result   <= '0;
        end else if (in_valid) begin
            match    <= dec.hit;
            wr_en    <= dec.hit && !dec.trap;
            unpred   <= dec.trap;
            dest_idx <= dec.rd;
            result   <= folded;
        end else begin
            match  <= 1'b0;
            wr_en  <= 1'b0;
            unpred <= 1'b0;
        end
    end

    AST_WRITE_OR_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && unpred)); // R5
    AST_FLAGS_NEED_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || unpred) |-> match); // R8
    AST_NO_PC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (dest_idx != PC_INDEX)); // R7
    AST_STROBE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_QUIET_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(match || wr_en || unpred)); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R9
endmodule

// File: tb/crc_instr_unit_test.sv
`timescale 1ns/1ps
module crc_instr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0, acc_val = '0, dat_val = '0;
    logic        out_valid, match, wr_en, unpred;
    logic [3:0]  dest_idx;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    crc_instr_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .acc_val(acc_val), .dat_val(dat_val), .out_valid(out_valid),
        .match(match), .wr_en(wr_en), .unpred(unpred),
        .dest_idx(dest_idx), .result(result)
    );

    function automatic logic [31:0] mk(input logic [3:0] cond, input logic [1:0] sz,
                                       input logic c, input logic [3:0] n,
                                       input logic [3:0] d, input logic [3:0] m);
        return {cond, 5'b00010, sz, 1'b0, n, d, 2'b00, c, 1'b0, 4'b0100, m};
    endfunction

    function automatic logic [31:0] ref_crc(input logic [31:0] acc, input logic [31:0] data,
                                            input int nbits, input logic c);
        logic [31:0] r, p;
        logic fb;
        r = acc;
        p = c ? 32'h82F63B78 : 32'hEDB88320;
        for (int i = 0; i < nbits; i++) begin
            fb = r[0] ^ data[i];
            r  = r >> 1;
            if (fb) r = r ^ p;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        instr = w; acc_val = a; dat_val = d; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic model_check(input logic [31:0] w, input logic [31:0] a, input logic [31:0] d);
        bit em, et;
        int nb;
        logic [31:0] er;
        issue(w, a, d);
        em = ((w & 32'h0F900DF0) == 32'h01000040);
        et = em && (w[31:28] != 4'hE || w[22:21] == 2'b11 ||
                    w[19:16] == 4'hF || w[15:12] == 4'hF || w[3:0] == 4'hF);
        chk(match == em, "R1 match", {31'd0, match}, {31'd0, em});
        chk(unpred == et, "R5/R6/R7 unpred", {31'd0, unpred}, {31'd0, et});
        chk(wr_en == (em && !et), "R2 wr_en", {31'd0, wr_en}, {31'd0, em && !et});
        if (!em) chk(!wr_en && !unpred, "R8 quiet", {30'd0, wr_en, unpred}, 32'd0);
        if (em && !et) begin
            nb = (w[22:21] == 2'b00) ? 8 : (w[22:21] == 2'b01) ? 16 : 32;
            er = ref_crc(a, d, nb, w[9]);
            chk(result == er, "R3/R4 result", result, er);
            chk(dest_idx == w[15:12], "R2 dest", {28'd0, dest_idx}, {28'd0, w[15:12]});
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] c, w;
        string s;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R10 reset values
        chk({out_valid, match, wr_en, unpred, dest_idx} == 8'd0 && result == 32'd0,
            "R10 reset", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 timing: one cycle after strobe
        issue(mk(4'hE, 2'b10, 1'b1, 4'd1, 4'd2, 4'd3), 32'hFFFFFFFF, 32'h12345678);
        chk(out_valid, "R9 out_valid", {31'd0, out_valid}, 32'd1);
        @(negedge clk);
        chk(!out_valid && !match && !wr_en, "R9 idle", {29'd0, out_valid, match, wr_en}, 32'd0);

        // R4 upper data bits ignored
        issue(mk(4'hE, 2'b00, 1'b0, 4'd1, 4'd2, 4'd3), 32'h0BADF00D, 32'hFFFFFF5A);
        chk(result == ref_crc(32'h0BADF00D, 32'h5A, 8, 1'b0), "R4 byte mask",
            result, ref_crc(32'h0BADF00D, 32'h5A, 8, 1'b0));
        issue(mk(4'hE, 2'b01, 1'b1, 4'd1, 4'd2, 4'd3), 32'h0BADF00D, 32'hABCD1234);
        chk(result == ref_crc(32'h0BADF00D, 32'h1234, 16, 1'b1), "R4 half mask",
            result, ref_crc(32'h0BADF00D, 32'h1234, 16, 1'b1));

        // R5, R6, R7 directed traps
        model_check(mk(4'hE, 2'b11, 1'b0, 4'd1, 4'd2, 4'd3), 32'h1, 32'h2);
        model_check(mk(4'h0, 2'b10, 1'b1, 4'd1, 4'd2, 4'd3), 32'h1, 32'h2);
        model_check(mk(4'hE, 2'b10, 1'b0, 4'd1, 4'd15, 4'd3), 32'h1, 32'h2);
        model_check(mk(4'hE, 2'b10, 1'b0, 4'd15, 4'd2, 4'd3), 32'h1, 32'h2);
        model_check(mk(4'hE, 2'b10, 1'b0, 4'd1, 4'd2, 4'd15), 32'h1, 32'h2);
        // R8 near misses: one fixed bit flipped
        model_check(mk(4'hE, 2'b10, 1'b0, 4'd1, 4'd2, 4'd3) ^ 32'h00000100, 32'h1, 32'h2);
        model_check(mk(4'hE, 2'b10, 1'b0, 4'd1, 4'd2, 4'd3) ^ 32'h00100000, 32'h1, 32'h2);

        // R3 check value, byte instructions chained
        s = "123456789";
        c = 32'hFFFFFFFF;
        for (int i = 0; i < 9; i++) begin
            issue(mk(4'hE, 2'b00, 1'b1, 4'd4, 4'd4, 4'd5), c, {24'd0, s[i]});
            c = result;
        end
        chk(~c == 32'hE3069283, "R3 check value bytes", ~c, 32'hE3069283);
        // R4 two words plus a byte, little-endian
        issue(mk(4'hE, 2'b10, 1'b1, 4'd4, 4'd4, 4'd5), 32'hFFFFFFFF, 32'h34333231);
        c = result;
        issue(mk(4'hE, 2'b10, 1'b1, 4'd4, 4'd4, 4'd5), c, 32'h38373635);
        c = result;
        issue(mk(4'hE, 2'b00, 1'b1, 4'd4, 4'd4, 4'd5), c, 32'h00000039);
        chk(~result == 32'hE3069283, "R4 check value words", ~result, 32'hE3069283);

        // Random mix
        for (int t = 0; t < 400; t++) begin
            if ($urandom % 8 == 0) w = $urandom;
            else w = mk(($urandom % 4 == 0) ? 4'($urandom) : 4'hE, 2'($urandom),
                        1'($urandom), 4'($urandom), 4'($urandom), 4'($urandom));
            model_check(w, $urandom, $urandom);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule